// File: doc/BRIEF.md
# Quadrature amplitude integrity monitor

This block watches the demodulated sine and cosine sample pairs of a resolver-to-digital path. It checks that the pairs keep a constant amplitude, because sin² + cos² stays constant for a healthy signal. Each square is scaled down by 2^16. The sum of the two scaled squares is then tested against a programmable high/low window. The check does not depend on rotor motion; every pair marked valid is evaluated.

Out-of-window pairs advance a consecutive-violation counter, and an in-window pair returns it to zero. When the counter reaches a programmable limit, a fault event occurs. That event sets a sticky too-high or too-low status flag and latches the two scaled squares of the offending pair. It also raises an interrupt if the matching enable is set. Software reads and configures the block through a small word-wide register port with four addresses.

Top module: `quad_amp_monitor`

## Requirements
- R1: After reset: window register (address 0) reads 0, capture register (address 1) reads 0, configuration register (address 2) reads 0x00000001 (limit 1, enables off), status register (address 3) reads 0, and `irq` is 0.
- R2: Each scaled square equals floor(x·x / 65536) for a signed 16-bit sample x, so −32768 gives 16384. The capture register holds the cosine square in bits 31:16 and the sine square in bits 15:0.
- R3: A pair violates when its unsigned sum of scaled squares is greater than the high bound (address 0 bits 31:16) or less than the low bound (address 0 bits 15:0). A sum equal to a bound is in-window.
- R4: Consecutive violations are counted and any in-window pair clears the count. A fault event occurs on the violation that brings the count to the limit (address 2 bits 7:0); a limit of 0 acts as 1. The count is cleared by the fault event.
- R5: On a fault event, status bit 4 (too high) is set if the completing pair exceeded the high bound, otherwise status bit 3 (too low) is set. When a pair is both above the high bound and below the low bound, bit 4 is chosen.
- R6: The capture register changes only on a fault event. Non-faulting pairs leave it unchanged.
- R7: Status bits stay set until software writes 1 to that bit position at address 3. Writing 0 leaves a bit unchanged.
- R8: `irq` is (status bit 4 AND enable at address 2 bit 12) OR (status bit 3 AND enable at address 2 bit 11).
- R9: Sample inputs with `smp_valid` low have no effect on the count, the status or the capture.
- R10: A fault becomes visible on the status and on `irq` right after the third rising clock edge, counting the edge that takes in the sample. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Qualifies the sample pair on this cycle |
| smp_sin | input | 16 | Signed demodulated sine sample |
| smp_cos | input | 16 | Signed demodulated cosine sample |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Enabled-fault interrupt |

## Verification
A miscounted violation counter shows up as a status flag that appears one pair too early or too late in a run of violations. That difference can be read out right after the pair that should have completed the count. A wrong direction choice or a stale capture shows up as a wrong status bit or capture word in the first readout after the fault. A pipeline slip moves the rise of `irq` by a whole cycle against the fixed three-edge latency.

// File: rtl/qam_pkg.sv
package qam_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 16;

  typedef enum logic [1:0] {
    ADDR_WIN  = 2'd0,
    ADDR_CAP  = 2'd1,
    ADDR_CFG  = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  localparam int STAT_HI_BIT = 4;
  localparam int STAT_LO_BIT = 3;
  localparam int EN_HI_BIT   = 12;
  localparam int EN_LO_BIT   = 11;
endpackage

// File: rtl/qam_square_sum.sv
module qam_square_sum #(
  parameter int SAMPLE_W = 16,
  parameter int SHIFT    = 16,
  parameter int THR_W    = 16,
  localparam int PROD_W  = 2 * SAMPLE_W,
  localparam int SQ_W    = PROD_W - SHIFT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sin,
  input  logic signed [SAMPLE_W-1:0] in_cos,
  input  logic        [THR_W-1:0]    thr_hi,
  input  logic        [THR_W-1:0]    thr_lo,
  output logic                       out_valid,
  output logic        [SQ_W-1:0]     out_sq_sin,
  output logic        [SQ_W-1:0]     out_sq_cos,
  output logic                       out_hi,
  output logic                       out_lo
);
  localparam int SUM_W = SQ_W + 1;
  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

  // stage 1: scaled squares
  logic signed [PROD_W-1:0] prod_sin, prod_cos;
  logic [SQ_W-1:0] s1_sin_q, s1_cos_q;
  logic            s1_valid_q;
  logic            unused_low;

  always_comb begin
    prod_sin = PROD_W'(in_sin) * PROD_W'(in_sin);
    prod_cos = PROD_W'(in_cos) * PROD_W'(in_cos);
  end
  assign unused_low = ^{prod_sin[SHIFT-1:0], prod_cos[SHIFT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_sin_q   <= '0;
      s1_cos_q   <= '0;
    end else begin
      s1_valid_q <= in_valid;
      if (in_valid) begin
        s1_sin_q <= prod_sin[PROD_W-1:SHIFT];
        s1_cos_q <= prod_cos[PROD_W-1:SHIFT];
      end
    end
  end

  // stage 2: sum and window compare
  logic [SUM_W-1:0] sum;
  logic             hi_d, lo_d;

  always_comb begin
    sum  = {1'b0, s1_sin_q} + {1'b0, s1_cos_q};
    hi_d = CMP_W'(sum) > CMP_W'(thr_hi);
    lo_d = CMP_W'(sum) < CMP_W'(thr_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sq_sin <= '0;
      out_sq_cos <= '0;
      out_hi     <= 1'b0;
      out_lo     <= 1'b0;
    end else begin
      out_valid <= s1_valid_q;
      if (s1_valid_q) begin
        out_sq_sin <= s1_sin_q;
        out_sq_cos <= s1_cos_q;
        out_hi     <= hi_d;
        out_lo     <= lo_d;
      end
    end
  end
endmodule

// File: rtl/qam_glitch_filter.sv
module qam_glitch_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_hi,
  input  logic             in_lo,
  input  logic [CNT_W-1:0] limit,
  output logic             fault_evt,
  output logic             fault_hi,
  output logic [CNT_W-1:0] cnt_q
);
  logic             viol;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    viol      = in_hi | in_lo;
    cnt_inc   = {1'b0, cnt_q} + 1'b1;
    fault_evt = in_valid & viol & (cnt_inc >= {1'b0, limit});
    fault_hi  = in_hi;
    cnt_d     = cnt_q;
    if (in_valid) begin
      if (!viol || fault_evt) cnt_d = '0;
      else                    cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qam_regs.sv
module qam_regs
  import qam_pkg::*;
#(
  parameter int SQ_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               fault_evt,
  input  logic               fault_hi,
  input  logic [SQ_W-1:0]    sq_sin,
  input  logic [SQ_W-1:0]    sq_cos,
  output logic [FIELD_W-1:0] thr_hi,
  output logic [FIELD_W-1:0] thr_lo,
  output logic [CNT_W-1:0]   limit,
  output logic [REG_W-1:0]   rdata,
  output logic [REG_W-1:0]   cap_q,
  output logic               stat_hi,
  output logic               stat_lo,
  output logic               irq
);
  logic en_hi, en_lo;
  logic wr_win, wr_cfg, wr_stat;
  logic stat_hi_d, stat_lo_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    wr_win    = wr_en && (addr == ADDR_WIN);
    wr_cfg    = wr_en && (addr == ADDR_CFG);
    wr_stat   = wr_en && (addr == ADDR_STAT);
    stat_hi_d = (stat_hi & ~(wr_stat & wdata[STAT_HI_BIT])) | (fault_evt & fault_hi);
    stat_lo_d = (stat_lo & ~(wr_stat & wdata[STAT_LO_BIT])) | (fault_evt & ~fault_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hi  <= '0;
      thr_lo  <= '0;
      limit   <= CNT_W'(1);
      en_hi   <= 1'b0;
      en_lo   <= 1'b0;
      cap_q   <= '0;
      stat_hi <= 1'b0;
      stat_lo <= 1'b0;
    end else begin
      if (wr_win) begin
        thr_hi <= wdata[2*FIELD_W-1:FIELD_W];
        thr_lo <= wdata[FIELD_W-1:0];
      end
      if (wr_cfg) begin
        limit <= wdata[CNT_W-1:0];
        en_hi <= wdata[EN_HI_BIT];
        en_lo <= wdata[EN_LO_BIT];
      end
      if (fault_evt) cap_q <= {FIELD_W'(sq_cos), FIELD_W'(sq_sin)};
      stat_hi <= stat_hi_d;
      stat_lo <= stat_lo_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      ADDR_WIN:  rdata = {thr_hi, thr_lo};
      ADDR_CAP:  rdata = cap_q;
      ADDR_CFG: begin
        rdata[CNT_W-1:0] = limit;
        rdata[EN_HI_BIT] = en_hi;
        rdata[EN_LO_BIT] = en_lo;
      end
      ADDR_STAT: begin
        rdata[STAT_HI_BIT] = stat_hi;
        rdata[STAT_LO_BIT] = stat_lo;
      end
      default: rdata = '0;
    endcase
    irq = (stat_hi & en_hi) | (stat_lo & en_lo);
  end
endmodule

// File: rtl/quad_amp_monitor.sv
module quad_amp_monitor
  import qam_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHIFT    = 16,
  parameter int CNT_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_sin,
  input  logic signed [SAMPLE_W-1:0] smp_cos,
  input  logic                       reg_wr_en,
  input  logic [1:0]                 reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  output logic                       irq
);
  localparam int SQ_W = 2 * SAMPLE_W - SHIFT;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [FIELD_W-1:0] thr_hi, thr_lo;
  logic [CNT_W-1:0]   limit, cnt_q;
  logic               s2_valid, s2_hi, s2_lo;
  logic [SQ_W-1:0]    s2_sq_sin, s2_sq_cos;
  logic               fault_evt, fault_hi;
  logic [REG_W-1:0]   cap_q;
  logic               stat_hi, stat_lo;

  qam_square_sum #(.SAMPLE_W(SAMPLE_W), .SHIFT(SHIFT), .THR_W(FIELD_W)) u_sq (
    .clk(clk), .rst_n(rst_int_n), .in_valid(smp_valid),
    .in_sin(smp_sin), .in_cos(smp_cos), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .out_valid(s2_valid), .out_sq_sin(s2_sq_sin), .out_sq_cos(s2_sq_cos),
    .out_hi(s2_hi), .out_lo(s2_lo)
  );

  qam_glitch_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .in_valid(s2_valid),
    .in_hi(s2_hi), .in_lo(s2_lo), .limit(limit),
    .fault_evt(fault_evt), .fault_hi(fault_hi), .cnt_q(cnt_q)
  );

  qam_regs #(.SQ_W(SQ_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .fault_evt(fault_evt), .fault_hi(fault_hi),
    .sq_sin(s2_sq_sin), .sq_cos(s2_sq_cos), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .limit(limit), .rdata(reg_rdata), .cap_q(cap_q),
    .stat_hi(stat_hi), .stat_lo(stat_lo), .irq(irq)
  );
endmodule

// File: rtl/qam_monitor_checker.sv
module qam_monitor_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             v2,
  input logic [CNT_W-1:0] cnt,
  input logic             fault_evt,
  input logic             fault_hi,
  input logic             stat_hi,
  input logic             stat_lo,
  input logic [31:0]      cap,
  input logic             irq
);
  a_r4_count_cleared_by_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (cnt == '0));

  a_r9_idle_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> $stable(cnt));

  a_r6_capture_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> $stable(cap));

  a_r5_hi_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_hi) |-> $past(fault_evt && fault_hi));

  a_r5_lo_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_lo) |-> $past(fault_evt && !fault_hi));

  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_hi || stat_lo));
endmodule

bind quad_amp_monitor qam_monitor_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .v2(s2_valid), .cnt(cnt_q),
  .fault_evt(fault_evt), .fault_hi(fault_hi), .stat_hi(stat_hi),
  .stat_lo(stat_lo), .cap(cap_q), .irq(irq)
);

// File: tb/quad_amp_monitor_test.sv
`timescale 1ns/1ps
module quad_amp_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_sin = '0, smp_cos = '0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  quad_amp_monitor uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sin(smp_sin),
    .smp_cos(smp_cos), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  int m_hi = 0, m_lo = 0, m_lim = 1, m_cnt = 0;
  bit m_enh = 0, m_enl = 0;
  logic [31:0] m_cap = '0;
  logic [31:0] m_st = '0;

  typedef struct { logic [31:0] st; logic [31:0] cap; logic irq; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic int sqs(int x);
    return (x * x) >>> 16;
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_win(int hi, int lo);
    m_hi = hi; m_lo = lo;
    wr(2'd0, {hi[15:0], lo[15:0]});
  endtask

  task automatic set_cfg(int lim, bit enh, bit enl);
    m_lim = lim; m_enh = enh; m_enl = enl;
    wr(2'd2, {19'd0, enh, enl, 3'd0, lim[7:0]});
  endtask

  task automatic clr(logic [31:0] mask);
    m_st = m_st & ~(mask & 32'h18);
    wr(2'd3, mask);
  endtask

  // driver: present one valid pair and advance the model
  task automatic send(int s, int c);
    int sum;
    bit hi, lo;
    @(negedge clk);
    smp_valid = 1'b1; smp_sin = 16'(s); smp_cos = 16'(c);
    sum = sqs(s) + sqs(c);
    hi = sum > m_hi; lo = sum < m_lo;
    if (hi || lo) begin
      if (m_cnt + 1 >= m_lim) begin
        m_cnt = 0;
        m_cap = {16'(sqs(c)), 16'(sqs(s))};
        if (hi) m_st[4] = 1'b1; else m_st[3] = 1'b1;
      end else m_cnt++;
    end else m_cnt = 0;
  endtask

  // driver: end the burst, let the pipeline drain, push the expectation
  task automatic flush(string tag);
    exp_t e;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    e.st = m_st; e.cap = m_cap;
    e.irq = (m_st[4] & m_enh) | (m_st[3] & m_enl);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pop an expectation and compare against the ports
  task automatic check_state();
    exp_t e;
    logic [31:0] d;
    e = sb_q.pop_front();
    rd(2'd3, d); chk({e.tag, " status"}, d, e.st);
    rd(2'd1, d); chk({e.tag, " capture"}, d, e.cap);
    chk({e.tag, " irq"}, {31'd0, irq}, {31'd0, e.irq});
  endtask

  initial begin
    logic [31:0] d;
    int s9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(2'd0, d); chk("R1 window", d, 32'h0);
    rd(2'd1, d); chk("R1 capture", d, 32'h0);
    rd(2'd2, d); chk("R1 config", d, 32'h1);
    rd(2'd3, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    set_win(26542, 16056);
    rd(2'd0, d); chk("R3 window readback", d, {16'd26542, 16'd16056});
    set_cfg(1, 1, 1);

    // R10 latency, R2 full-scale squares
    send(-32768, -32768);
    @(negedge clk); smp_valid = 1'b0;
    chk("R10 irq after edge 1", {31'd0, irq}, 32'h0);
    @(negedge clk); chk("R10 irq after edge 2", {31'd0, irq}, 32'h0);
    @(negedge clk); chk("R10 irq after edge 3", {31'd0, irq}, 32'h1);
    rd(2'd1, d); chk("R2 capture full scale", d, 32'h4000_4000);
    sb_q.push_back('{m_st, m_cap, 1'b1, "R5 hi fault"});
    check_state();

    // R7 write-one-to-clear, zero write ignored
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R7 zero write keeps", d, 32'h10);
    clr(32'h10); flush("R7 cleared"); check_state();

    // R5 low fault
    send(100, 100); flush("R5 lo fault"); check_state();
    clr(32'h18);

    // R5 both bounds crossed -> high wins
    set_win(10, 20000);
    send(1024, 0); flush("R5 hi priority"); check_state();
    clr(32'h18);

    // R3 boundaries
    s9 = sqs(20000) + sqs(15000);
    set_win(s9, s9);
    send(20000, 15000); flush("R3 sum equals both bounds"); check_state();
    set_win(s9 - 1, 0);
    send(20000, 15000); flush("R3 above high"); check_state();
    clr(32'h18);
    set_win(26542, s9 + 1);
    send(15000, 20000); flush("R3 below low"); check_state();
    clr(32'h18);

    // R4 consecutive counting, R6 capture hold
    set_win(26542, 16056);
    set_cfg(3, 1, 1);
    send(-32768, -32768); send(0, 0); flush("R4 two violations"); check_state();
    send(-32768, 0); flush("R4 in-window clears"); check_state();
    send(0, 0); send(32767, 32767); flush("R6 no new fault"); check_state();
    send(-32768, -32768); flush("R4 third violation faults"); check_state();
    clr(32'h18);
    send(0, 0); send(0, 0); flush("R4 count reset by fault"); check_state();
    send(-32768, 0); flush("R4 clear"); check_state();

    // R9 invalid pairs ignored
    set_cfg(2, 1, 1);
    send(0, 0); flush("R9 first violation"); check_state();
    @(negedge clk); smp_sin = 16'sd0; smp_cos = 16'sd0;
    repeat (5) @(negedge clk);
    sb_q.push_back('{m_st, m_cap, 1'b0, "R9 invalid ignored"}); check_state();
    send(-32768, -32768); flush("R9 second violation faults"); check_state();

    // R8 enables
    set_cfg(1, 0, 1);
    chk("R8 hi disabled", {31'd0, irq}, 32'h0);
    set_cfg(1, 1, 0);
    chk("R8 hi enabled", {31'd0, irq}, 32'h1);
    clr(32'h18);
    send(100, 100); flush("R8 lo disabled"); check_state();
    set_cfg(1, 0, 1);
    chk("R8 lo enabled", {31'd0, irq}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule